// File: doc/BRIEF.md
# Fractional Scale/Step Baud Generator

This block makes the bit-rate enable for a UART serial engine. It does not divide the clock by a whole number. A prescaler first thins the clock to one enable every `scale + 1` cycles. On each of those enables, a `step` value is added into an accumulator one bit wider than the step field. Each time that addition overflows, the block sends out a single-cycle tick. The remainder stays in the accumulator, so the small error of a fractional ratio is carried forward and does not build up. The long-run tick rate is `f_clk * step / (2^17 * (scale + 1))` with the default widths.

Software works out the best scale and step for the reference clock it has, usually 25 MHz and sometimes 40 MHz. It then writes both values in one access to a single configuration word. Every write loads both fields and restarts the prescaler and the accumulator. A stored step of zero keeps the tick output quiet.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset `baud_tick` is low and `cfg_rdata` reads zero, so scale = 0 and step = 0.
- R2: A write with `cfg_we` high loads step from bits 15:0 and scale from bits 23:16 of `cfg_wdata`, and bits 31:24 are dropped. From the next cycle, `cfg_rdata` returns the two fields in the same bit positions, with bits 31:24 reading zero.
- R3: Count clock edges from the write edge, so the write edge is t = 0. An enable happens at each edge t where t is a multiple of scale+1, and j = t/(scale+1) is the number of that enable. `baud_tick` is high in the cycle after edge t exactly when floor(j*step/2^17) is greater than floor((j-1)*step/2^17).
- R4: `baud_tick` is one cycle wide and is never high in two cycles in a row.
- R5: A write clears the prescaler and the accumulator. The tick pattern that follows depends only on the new fields, whatever state the block was in before, and `baud_tick` is low in the cycle after the write.
- R6: While the stored step is zero, `baud_tick` stays low.
- R7: Ticks only come on prescaler boundaries. With scale = 255, enables are 256 edges apart, and the long-run count of ticks follows the rate formula with no drift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: step in 15:0, scale in 23:16 |
| cfg_rdata | output | 32 | Stored configuration word, with unused bits zero |
| baud_tick | output | 1 | Single-cycle bit-rate enable |

## Verification
The bench builds the block with its default widths: a 16-bit step, an 8-bit scale and a 32-bit configuration word. With these widths the accumulator is 17 bits, so the bench can compute the exact position of every tick from the formula in R3. These widths allow the largest scale of 255 and the largest step of 0xFFFF, so both the slowest prescaler and the densest tick pattern can be tested. Having a spare upper byte in the word lets the bench write junk into the dropped bits and check that it has no effect.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int REG_W   = 32,
  parameter int STEP_W  = 16,
  parameter int SCALE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             baud_tick
);
  localparam int ACC_W = STEP_W + 1;
  localparam int PAD_W = REG_W - STEP_W - SCALE_W;

  logic [STEP_W-1:0]  step_q;
  logic [SCALE_W-1:0] scale_q;
  logic [SCALE_W-1:0] presc_q;
  logic [ACC_W-1:0]   acc_q;
  logic               tick_q;

  logic             presc_hit;
  logic [ACC_W:0]   acc_sum;

  assign presc_hit = (presc_q == scale_q);
  assign acc_sum   = {1'b0, acc_q} + {{(ACC_W + 1 - STEP_W){1'b0}}, step_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      scale_q <= '0;
      presc_q <= '0;
      acc_q   <= '0;
      tick_q  <= 1'b0;
    end else if (cfg_we) begin
      step_q  <= cfg_wdata[STEP_W-1:0];
      scale_q <= cfg_wdata[STEP_W +: SCALE_W];
      presc_q <= '0;
      acc_q   <= '0;
      tick_q  <= 1'b0;
    end else if (presc_hit) begin
      presc_q <= '0;
      acc_q   <= acc_sum[ACC_W-1:0];
      tick_q  <= acc_sum[ACC_W];
    end else begin
      presc_q <= presc_q + 1'b1;
      tick_q  <= 1'b0;
    end
  end

  assign cfg_rdata = {{PAD_W{1'b0}}, scale_q, step_q};
  assign baud_tick = tick_q;
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int REG_W   = 32,
  parameter int STEP_W  = 16,
  parameter int SCALE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             baud_tick
);
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  assert_write_quiets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !baud_tick);

  assert_zero_step_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[STEP_W-1:0] == '0) |-> !baud_tick);

  assert_field_pack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == {{(REG_W-STEP_W-SCALE_W){1'b0}},
                             $past(cfg_wdata[STEP_W+SCALE_W-1:0])}));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .REG_W(REG_W), .STEP_W(STEP_W), .SCALE_W(SCALE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .baud_tick(baud_tick)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        baud_tick;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .baud_tick(baud_tick)
  );

  localparam int NVEC = 7;
  localparam logic [31:0] VEC_WORD [NVEC] = '{
    32'h0000_8000, 32'hA500_FFFF, 32'h0002_3000, 32'h0001_1234,
    32'h0000_4CCD, 32'hFF03_0001, 32'h00FF_8000};
  localparam int VEC_LEN [NVEC] = '{40, 100, 300, 500, 200, 60, 3000};

  function automatic bit exp_tick(int t, int scale, int step);
    int  s1 = scale + 1;
    longint j;
    if (t % s1 != 0) return 1'b0;
    j = t / s1;
    return ((j * step) >> 17) != (((j - 1) * step) >> 17);
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic run_window(input logic [31:0] w, input int len, input string req);
    int scale = int'(w[23:16]);
    int step  = int'(w[15:0]);
    int bad = 0;
    int first_t = 0;
    bit first_a = 1'b0;
    bit first_e = 1'b0;
    write_cfg(w);
    for (int t = 1; t <= len; t++) begin
      bit e;
      @(posedge clk);
      #1;
      e = exp_tick(t, scale, step);
      if (baud_tick !== e) begin
        if (bad == 0) begin
          first_t = t;
          first_a = baud_tick;
          first_e = e;
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s word %h edge %0d: actual %0b expected %0b", req, w, first_t, first_a, first_e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (baud_tick !== 1'b0 || cfg_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 during reset: actual tick %b rdata %h expected 0 0", baud_tick, cfg_rdata);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (baud_tick !== 1'b0 || cfg_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 after reset: actual tick %b rdata %h expected 0 0", baud_tick, cfg_rdata);
    end

    // R3 tick placement per vector; R7 with scale 255
    for (int v = 0; v < NVEC; v++)
      run_window(VEC_WORD[v], VEC_LEN[v], (v == NVEC - 1) ? "R7" : "R3");

    // R2 field packing with junk in the dropped byte
    write_cfg(32'h5A12_3456);
    checks++;
    if (cfg_rdata !== 32'h0012_3456) begin
      errors++;
      $display("FAIL R2 packing: actual %h expected %h", cfg_rdata, 32'h0012_3456);
    end

    // R6 zero step gives no ticks
    run_window(32'h0000_0000, 600, "R6");
    run_window(32'hFFFF_0000, 600, "R6");

    // R5 accumulator cleared by a rewrite
    write_cfg(32'h0000_8000);
    repeat (3) @(posedge clk);
    run_window(32'h0000_8000, 12, "R5");

    // R5 prescaler cleared by a rewrite
    write_cfg(32'h0003_FFFF);
    repeat (2) @(posedge clk);
    run_window(32'h0003_FFFF, 40, "R5");

    // R4 single-cycle ticks at the densest setting
    begin
      int pairs = 0;
      bit prev = 1'b0;
      write_cfg(32'h0000_FFFF);
      for (int t = 0; t < 200; t++) begin
        @(posedge clk);
        #1;
        if (prev && baud_tick) pairs++;
        prev = baud_tick;
      end
      checks++;
      if (pairs != 0) begin
        errors++;
        $display("FAIL R4 back-to-back ticks: actual %0d expected 0", pairs);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule